// File: doc/BRIEF.md
# Two-Phase Reload Timer Pair

This block holds two identical down-counting timers behind a small word-addressed register bus. Each timer period has two phases. In the low phase the timer output is 0, and its length comes from a low-count register. In the high phase the output is 1, and its length comes from a high-count register. The full period is therefore the sum of the two values. At the end of every period the timer reloads both phases from the values it captured at enable, raises a single-cycle interrupt, and starts again. It repeats while its enable bit stays set.

Software programs a timer in three steps. It clears the timer's enable bit, writes the two count registers, then sets the enable bit again. Count writes made while a timer runs are not seen until the next enable. A zero count cannot be used, so it is run as a count of 1 and reported in a status bit. A live counter register gives the number of cycles elapsed in the current phase. Timer 0 loaded with all-ones low count and a high count of 1 therefore serves as a free-running up-counting time base. A watchdog-mode flag is reported when timer 0's low count holds 0xFF; nothing acts on that flag inside the block.

Top module: `tmr_pair`

## Requirements
- R1: Word address map. Address 0 is control/status. Addresses 1 and 2 are timer 1's low and high counts; addresses 3 and 4 are timer 0's low and high counts. Addresses 5 and 6 are the live counters of timers 0 and 1. Count registers read back what was written. Control bit 0 enables timer 0 and bit 1 enables timer 1; both read back. Everything resets to 0.
- R2: The write that changes a timer's enable bit from 0 to 1 starts that timer at once. After that clock edge the timer is in its low phase, its output is 0 and its live counter reads 0. Writing 1 to a bit that is already 1 does not restart the timer.
- R3: A running timer's output is 0 for L cycles, then 1 for H cycles, and repeats with period L+H. Here L and H are the low and high counts captured at enable.
- R4: The interrupt line of a running timer is 1 for exactly one cycle per period. That cycle is the first cycle of each new period, when the phases have reloaded; it is never in the first period after enable.
- R5: The live counter of a timer reads the number of cycles elapsed in its current phase. It starts at 0 at each phase start.
- R6: A count register value of 0 is run as a count of 1. Status bit 4 (timer 0) or bit 5 (timer 1) of address 0 reads 1 while either count register of that timer holds 0. With both counts at 0 the period is the minimum of 2 cycles.
- R7: Writes to a running timer's count registers do not change its current or later periods until the next enable.
- R8: While a timer is disabled its live counter holds its value, its output is 0 and it raises no interrupt. Enabling it again starts a fresh low phase.
- R9: Status bit 8 of address 0 reads 1 while timer 0's low-count register holds 0x000000FF, and 0 otherwise.
- R10: Timer 0 enabled with a low count of 0xFFFFFFFF and a high count of 1 has a live counter that rises by exactly one per cycle.
- R11: The two timers run independently. Starting, stopping or reprogramming one does not alter the other's output, interrupt or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for bus_addr (combinational) |
| tout_o | output | 2 | Timer outputs, bit i for timer i |
| irq_o | output | 2 | Period-end interrupt pulses, bit i for timer i |

## Verification
The hardest case to reach from the ports is a count rewrite or a stop of one timer that lands in the middle of a phase of that timer, while the other timer is still running. The stimulus reaches it by starting the two timers on different cycles with random phase lengths. Count registers are then rewritten and single enable bits are cleared at cycles that fall inside a phase. Both timers are compared every cycle against a bench model of phase position. Directed cases add zero counts, the two-cycle minimum period and the all-ones free-running count.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

    localparam int NT          = 2;     // number of timers
    localparam int A_CTRL      = 0;     // control / status word
    localparam int ST_ZERO_LSB = 4;     // first zero-count status bit
    localparam int ST_WDOG     = 8;     // watchdog-mode flag bit
    localparam logic [7:0] WDOG_CODE = 8'hFF;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Timer 1 sits below timer 0 in the map.
    function automatic int low_addr(input int i);
        return 3 - 2 * i;
    endfunction

    function automatic int high_addr(input int i);
        return 4 - 2 * i;
    endfunction

    function automatic int live_addr(input int i);
        return 5 + i;
    endfunction

endpackage

// File: rtl/tmr_pair_regs.sv
module tmr_pair_regs
    import tmr_pair_pkg::*;
#(
    parameter int CW = 32,
    parameter int AW = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [AW-1:0]          addr,
    input  logic                   wr,
    input  logic [CW-1:0]          wdata,
    input  logic [NT-1:0][CW-1:0]  elapsed,
    output logic [CW-1:0]          rdata,
    output logic [NT-1:0]          en_next,
    output logic [NT-1:0]          start,
    output logic [NT-1:0][CW-1:0]  low_cnt,
    output logic [NT-1:0][CW-1:0]  high_cnt
);

    logic [NT-1:0] en_q;
    logic          ctrl_wr;
    logic [NT-1:0] zero_flag;
    logic          wdog_flag;

    assign ctrl_wr = wr && (addr == AW'(A_CTRL));
    assign en_next = ctrl_wr ? wdata[NT-1:0] : en_q;
    assign start   = en_next & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            en_q <= en_next;
            for (int i = 0; i < NT; i++) begin
                if (wr && addr == AW'(low_addr(i)))  low_cnt[i]  <= wdata;
                if (wr && addr == AW'(high_addr(i))) high_cnt[i] <= wdata;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NT; i++)
            zero_flag[i] = (low_cnt[i] == '0) || (high_cnt[i] == '0);
    end

    assign wdog_flag = (low_cnt[0] == CW'(WDOG_CODE));

    always_comb begin
        rdata = '0;
        if (addr == AW'(A_CTRL)) begin
            rdata[NT-1:0]                    = en_q;
            rdata[ST_ZERO_LSB +: NT]         = zero_flag;
            rdata[ST_WDOG]                   = wdog_flag;
        end
        for (int i = 0; i < NT; i++) begin
            if (addr == AW'(low_addr(i)))  rdata = low_cnt[i];
            if (addr == AW'(high_addr(i))) rdata = high_cnt[i];
            if (addr == AW'(live_addr(i))) rdata = elapsed[i];
        end
    end

    // R1: a control write lands in the enable register
    assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (en_q == $past(wdata[NT-1:0])));

    // R7: count registers only move on a write to their own address
    assert_low_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(low_cnt) && $stable(high_cnt));

endmodule

// File: rtl/tmr_pair_chan.sv
module tmr_pair_chan
    import tmr_pair_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          run_i,
    input  logic [CW-1:0] low_i,
    input  logic [CW-1:0] high_i,
    output logic          tout_o,
    output logic          irq_o,
    output logic [CW-1:0] elapsed_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [CW-1:0] low;
        logic [CW-1:0] high;
    } chan_st_t;

    chan_st_t st_q;
    logic     act_q;
    logic     irq_q;
    logic [CW-1:0] low_eff, high_eff;

    assign low_eff  = (low_i  == '0) ? ONE : low_i;
    assign high_eff = (high_i == '0) ? ONE : high_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{ph: PH_LOW, cnt: ONE, low: ONE, high: ONE};
            act_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            act_q <= run_i;
            irq_q <= 1'b0;
            if (start_i) begin
                st_q <= '{ph: PH_LOW, cnt: low_eff, low: low_eff, high: high_eff};
            end else if (run_i) begin
                if (st_q.cnt == ONE) begin
                    if (st_q.ph == PH_LOW) begin
                        st_q.ph  <= PH_HIGH;
                        st_q.cnt <= st_q.high;
                    end else begin
                        st_q.ph  <= PH_LOW;
                        st_q.cnt <= st_q.low;
                        irq_q    <= 1'b1;
                    end
                end else begin
                    st_q.cnt <= st_q.cnt - ONE;
                end
            end
        end
    end

    assign tout_o    = act_q && (st_q.ph == PH_HIGH);
    assign irq_o     = irq_q;
    assign elapsed_o = ((st_q.ph == PH_LOW) ? st_q.low : st_q.high) - st_q.cnt;

    // R4: the interrupt never lasts more than one cycle
    assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R3: an interrupt coincides with a freshly reloaded low phase
    assert_irq_reload_R3: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (st_q.ph == PH_LOW) && (elapsed_o == '0));

    // R8: an idle timer is silent
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !act_q |-> (!tout_o && !irq_o));

    // R8: an idle timer keeps its position
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> $stable(st_q.cnt) && $stable(st_q.ph));

    // R2: a start leaves the output low at phase position zero
    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!tout_o && elapsed_o == '0));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int CW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic [NT-1:0] tout_o,
    output logic [NT-1:0] irq_o
);

    logic [NT-1:0]          en_next;
    logic [NT-1:0]          start;
    logic [NT-1:0][CW-1:0]  low_cnt;
    logic [NT-1:0][CW-1:0]  high_cnt;
    logic [NT-1:0][CW-1:0]  elapsed;

    tmr_pair_regs #(.CW(CW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .elapsed  (elapsed),
        .rdata    (bus_rdata),
        .en_next  (en_next),
        .start    (start),
        .low_cnt  (low_cnt),
        .high_cnt (high_cnt)
    );

    for (genvar i = 0; i < NT; i++) begin : g_chan
        tmr_pair_chan #(.CW(CW)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .start_i   (start[i]),
            .run_i     (en_next[i]),
            .low_i     (low_cnt[i]),
            .high_i    (high_cnt[i]),
            .tout_o    (tout_o[i]),
            .irq_o     (irq_o[i]),
            .elapsed_o (elapsed[i])
        );
    end

endmodule

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
    import tmr_pair_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 32;
    localparam int AW = 3;
    localparam int MAX_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic [1:0]    tout_o, irq_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // bench model
    longint m_j[2], m_lt[2], m_lp[2];
    bit     m_act[2], m_fresh[2], m_en[2];
    logic [31:0] sh_low[2], sh_high[2];

    tmr_pair #(.CW(CW), .AW(AW)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tout_o(tout_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint eff(input logic [31:0] v);
        return (v == 0) ? 64'd1 : longint'(v);
    endfunction

    function automatic longint pos(input int t);
        return m_j[t] % (m_lt[t] + m_lp[t]);
    endfunction

    function automatic logic exp_out(input int t);
        return m_act[t] && (pos(t) >= m_lt[t]);
    endfunction

    function automatic logic exp_irq(input int t);
        return m_act[t] && (m_j[t] > 0) && (pos(t) == 0);
    endfunction

    function automatic longint exp_el(input int t);
        return (pos(t) < m_lt[t]) ? pos(t) : pos(t) - m_lt[t];
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[0] = m_en[0];
        s[1] = m_en[1];
        for (int t = 0; t < 2; t++)
            s[ST_ZERO_LSB + t] = (sh_low[t] == 0) || (sh_high[t] == 0);
        s[ST_WDOG] = (sh_low[0] == 32'hFF);
        return s;
    endfunction

    task automatic chk(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic peek(input int a, output logic [31:0] v);
        bus_addr = AW'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic step();
        @(negedge clk);
        bus_wr = 1'b0;
        for (int t = 0; t < 2; t++) begin
            if (m_act[t] && !m_fresh[t]) m_j[t]++;
            m_fresh[t] = 0;
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        if (a == A_CTRL) begin
            for (int t = 0; t < 2; t++) begin
                if (d[t] && !m_en[t]) begin
                    m_act[t] = 1; m_fresh[t] = 1; m_j[t] = 0;
                    m_lt[t] = eff(sh_low[t]); m_lp[t] = eff(sh_high[t]);
                end else if (!d[t]) begin
                    m_act[t] = 0;
                end
                m_en[t] = d[t];
            end
        end else begin
            for (int t = 0; t < 2; t++) begin
                if (a == low_addr(t))  sh_low[t]  = d;
                if (a == high_addr(t)) sh_high[t] = d;
            end
        end
        step();
    endtask

    // compare both timers against the model: R3 output, R4 irq, R5 counter, R11 independence
    task automatic check_all(input string tag);
        logic [31:0] v;
        for (int t = 0; t < 2; t++) begin
            chk($sformatf("R3 %s tout%0d", tag, t), longint'(tout_o[t]), longint'(exp_out(t)));
            chk($sformatf("R4 %s irq%0d", tag, t), longint'(irq_o[t]), longint'(exp_irq(t)));
            peek(live_addr(t), v);
            chk($sformatf("R5 %s live%0d", tag, t), longint'(v), exp_el(t));
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            step();
            check_all(tag);
        end
    endtask

    task automatic check_status(input string tag);
        logic [31:0] v;
        peek(A_CTRL, v);
        chk(tag, longint'(v), longint'(exp_status()));
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, prev;
        int unused;
        unused = $urandom(32'd20240611);
        for (int t = 0; t < 2; t++) begin
            m_j[t] = 0; m_lt[t] = 1; m_lp[t] = 1;
            m_act[t] = 0; m_fresh[t] = 0; m_en[t] = 0;
            sh_low[t] = 0; sh_high[t] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check_status("R1 R6 reset status");
        chk("R8 reset tout", longint'(tout_o), 0);
        chk("R8 reset irq", longint'(irq_o), 0);
        check_all("reset");

        // register readback
        for (int a = 1; a <= 4; a++) begin
            logic [31:0] d = $urandom;
            bus_write(a, d);
            peek(a, v);
            chk($sformatf("R1 readback addr %0d", a), longint'(v), longint'(d));
        end

        // random phase lengths, staggered starts
        for (int it = 0; it < 5; it++) begin
            bus_write(A_CTRL, 32'h0);
            for (int t = 0; t < 2; t++) begin
                bus_write(low_addr(t),  ($urandom % 12) + 1);
                bus_write(high_addr(t), ($urandom % 12) + 1);
            end
            bus_write(A_CTRL, 32'h1);
            check_all("R2 start t0");
            run(int'($urandom % 7), "R11 t0 alone");
            bus_write(A_CTRL, 32'h3);
            check_all("R2 start t1");
            check_status("R1 status running");
            run(40, "R3 both");

            // rewrite counts mid-run: no effect until next enable
            bus_write(low_addr(1), ($urandom % 12) + 1);
            bus_write(high_addr(0), ($urandom % 12) + 1);
            run(30, "R7 rewrite");
            bus_write(A_CTRL, 32'h3);   // already on: no restart
            run(10, "R2 no restart");

            // stop timer 1 only, then restart
            bus_write(A_CTRL, 32'h1);
            run(15, "R8 stopped");
            bus_write(A_CTRL, 32'h3);
            check_all("R8 restart");
            run(25, "R8 after restart");
        end

        // zero counts: run as 1, flagged; minimum period 2
        bus_write(A_CTRL, 32'h0);
        bus_write(low_addr(1), 32'h0);
        bus_write(high_addr(1), 32'd3);
        check_status("R6 zero flag t1");
        bus_write(low_addr(0), 32'h0);
        bus_write(high_addr(0), 32'h0);
        check_status("R6 zero flag both");
        bus_write(A_CTRL, 32'h3);
        run(12, "R6 zero run");
        bus_write(low_addr(1), 32'd2);
        check_status("R6 flag clears t1");

        // watchdog flag
        bus_write(low_addr(0), 32'hFF);
        check_status("R9 wdog set");
        bus_write(low_addr(0), 32'h1FF);
        check_status("R9 wdog clear");

        // free-running time base on timer 0
        bus_write(A_CTRL, 32'h2);
        bus_write(low_addr(0), 32'hFFFF_FFFF);
        bus_write(high_addr(0), 32'h1);
        bus_write(A_CTRL, 32'h3);
        for (int k = 0; k < 20; k++) begin
            peek(live_addr(0), prev);
            step();
            peek(live_addr(0), v);
            chk("R10 free-run increment", longint'(v), longint'(prev) + 1);
            check_all("R10 free-run");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule